// File: doc/BRIEF.md
# Priority-Preemptive External Interrupt Controller

This block collects up to 64 external interrupt lines and tells a processor core which one to service next. Software gives each line an enable bit, a force bit and a 4-bit priority. A line is eligible when it is enabled, it is pending (its hardware input or its force bit is high), and its priority is at or above the current preemption level. The single request output `irq_req` is high while any line is eligible.

A handler reads the next-interrupt register. That register gives the winning line number pre-scaled by four, so software can use it directly as an offset into a table of handler words. In the same access, software writes bit 0 of that register to latch the winner as the active interrupt. The latch sets the preemption level to the winner's priority plus one, so only strictly higher-priority lines can preempt it. The context register holds that level, the active line and a no-interrupt flag. A handler saves the context word on entry and writes it back on exit, which lets nested handlers unwind correctly. While the context is saved, the core's timer and software interrupt enables can be parked inside the context word.

All registers are 32-bit words on a plain read/write port. Reads are combinational and writes take effect at the clock edge. There is no stream data path, so the port has no valid/ready handshake.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, force and priority field is 0. The context word reads 0x0000_8000 (no-interrupt flag set, level 0). The next-interrupt register reads 0x8000_0000. `irq_req`, `soft_irq_en` and `timer_irq_en` are 0.
- R2: Line n is eligible when all three hold: its enable bit is 1, (`irq_in[n]` OR its force bit) is 1, and its priority is >= the current 5-bit preemption level. `irq_req` is 1 exactly when some line is eligible.
- R3: Enable words sit at address 0x00+(n>>4), pending words at 0x10+(n>>4) and force words at 0x20+(n>>4). Line n uses bit (n & 15) of its word. A pending word reads `irq_in` OR force, and writes to it are ignored.
- R4: Priority words sit at 0x40+(n>>2). Line n's 4-bit priority occupies bits [4*(n%4)+3 : 4*(n%4)] of its word.
- R5: The next-interrupt register at 0x80 reads as follows. Bit 31 is 1 when no line is eligible. Bits 10:2 hold the winning line number, and all other bits are 0. The winner is the eligible line with the highest priority. Among equal priorities, the lowest line number wins. With no eligible line, bits 10:2 read 0.
- R6: A write to 0x80 with bit 0 set loads the context from the winner at that edge. The level becomes priority+1, so priority 15 gives level 16 and nothing can preempt it. The line field becomes the winner, and the no-interrupt flag is cleared. With no winner, the write loads level 0, line 0 and the no-interrupt flag 1. A write to 0x80 with bit 0 clear changes nothing.
- R7: The next-interrupt register and the context update use the eligible set at the moment of the access. A higher-priority line that becomes pending before the sample is the one reported and latched.
- R8: The context word at 0x81 is laid out as follows. Bits 20:16 hold the level, bit 15 the no-interrupt flag and bits 12:4 the active line. Bit 3 holds the saved timer enable and bit 2 the saved software enable. All other bits read 0. A write loads all of these fields.
- R9: A context write with bit 1 set copies the live timer and software enables into bits 3 and 2, then clears both enables. A context write with bit 1 clear loads both enables from bits 3 and 2 of the written word.
- R10: The local enable word at 0x82 holds the software enable in bit 0 and the timer enable in bit 1. These bits drive `soft_irq_en` and `timer_irq_en`.
- R11: Force bits are software-written. Writing 0 to a force bit clears it, and the line then stops being pending unless its input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level-sensitive external interrupt lines |
| reg_addr | input | 8 | Register word address |
| reg_wen | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request toward the core |
| soft_irq_en | output | 1 | Software interrupt enable toward the core |
| timer_irq_en | output | 1 | Timer interrupt enable toward the core |

## Verification
The assertions check the following on every cycle:
- `irq_req` is high only when the winning line meets the preemption level.
- The winner is eligible, and no eligible line outranks it or wins a tie against it.
- A context update latches the sampled winner.
- A clear-and-save write clears both local enables.

Only the bench scenarios can show the rest: the exact word layouts, late arrival before the sample, the saturation at level 16 for the top priority, and a save-then-restore sequence that returns the enables and the preemption level to their old values.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W  = 4;
  localparam int LVL_W   = PRIO_W + 1;
  localparam int LINE_W  = 9;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] ENA_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] PND_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] FRC_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] PRI_BASE = 8'h40;
  localparam logic [ADDR_W-1:0] NXT_ADDR = 8'h80;
  localparam logic [ADDR_W-1:0] CTX_ADDR = 8'h81;
  localparam logic [ADDR_W-1:0] LCL_ADDR = 8'h82;

  // context word field positions
  localparam int CTX_LVL_LSB  = 16;
  localparam int CTX_NONE_BIT = 15;
  localparam int CTX_LINE_LSB = 4;
  localparam int CTX_TSAV_BIT = 3;
  localparam int CTX_SSAV_BIT = 2;
  localparam int CTX_PARK_BIT = 1;

  typedef struct packed {
    logic [LVL_W-1:0]  level;
    logic              none;
    logic [LINE_W-1:0] line;
    logic              t_sav;
    logic              s_sav;
  } ctx_t;
endpackage

// File: rtl/pic_select.sv
module pic_select import pic_pkg::*; #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 6
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        elig_i,
  input  logic [NUM_LINES*PRIO_W-1:0] pri_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [PRIO_W-1:0]           pri_o
);
  localparam int LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0]    hit;
  logic [PRIO_W-1:0]    top;
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] onehot;

  // which priority levels have at least one eligible line
  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      for (int l = 0; l < LEVELS; l++) begin
        if (elig_i[i] && pri_i[i*PRIO_W +: PRIO_W] == PRIO_W'(l)) hit[l] = 1'b1;
      end
    end
  end

  always_comb begin
    top = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (hit[l]) top = PRIO_W'(l);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      cand[i] = elig_i[i] && (pri_i[i*PRIO_W +: PRIO_W] == top);
    end
  end

  // isolate lowest-numbered candidate
  assign onehot = cand & (~cand + 1'b1);
  assign any_o  = |elig_i;

  // OR-accumulate: every line contributes, masked by its select bit
  always_comb begin
    idx_o = '0;
    pri_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      idx_o = idx_o | (IDX_W'(i) & {IDX_W{onehot[i]}});
      pri_o = pri_o | (pri_i[i*PRIO_W +: PRIO_W] & {PRIO_W{onehot[i]}});
    end
  end

  p_win_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> elig_i[idx_o]);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    p_winner_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      elig_i[g] |-> pri_i[g*PRIO_W +: PRIO_W] <= pri_o);
    p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (elig_i[g] && pri_i[g*PRIO_W +: PRIO_W] == pri_o) |-> (IDX_W'(g) >= idx_o));
  end
endmodule

// File: rtl/pic_context.sv
module pic_context import pic_pkg::*; #(
  parameter int                IDX_W     = 6,
  parameter logic [PRIO_W-1:0] PRIO_MASK = '1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_we,
  input  logic              lcl_we,
  input  logic              upd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              win_any,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [PRIO_W-1:0] win_pri,
  output logic [LVL_W-1:0]  level_o,
  output logic [DATA_W-1:0] ctx_word_o,
  output logic              soft_en_o,
  output logic              timer_en_o
);
  ctx_t ctx_q;
  logic soft_q, timer_q;
  logic [LVL_W-1:0] next_lvl;

  assign next_lvl = ({1'b0, win_pri} + LVL_W'(1)) & {1'b1, PRIO_MASK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= '{level: '0, none: 1'b1, line: '0, t_sav: 1'b0, s_sav: 1'b0};
      soft_q  <= 1'b0;
      timer_q <= 1'b0;
    end else if (upd) begin
      ctx_q.level <= win_any ? next_lvl : '0;
      ctx_q.none  <= !win_any;
      ctx_q.line  <= win_any ? LINE_W'(win_idx) : '0;
    end else if (ctx_we) begin
      ctx_q.level <= wdata[CTX_LVL_LSB +: LVL_W];
      ctx_q.none  <= wdata[CTX_NONE_BIT];
      ctx_q.line  <= wdata[CTX_LINE_LSB +: LINE_W];
      if (wdata[CTX_PARK_BIT]) begin
        ctx_q.t_sav <= timer_q;
        ctx_q.s_sav <= soft_q;
        timer_q     <= 1'b0;
        soft_q      <= 1'b0;
      end else begin
        ctx_q.t_sav <= wdata[CTX_TSAV_BIT];
        ctx_q.s_sav <= wdata[CTX_SSAV_BIT];
        timer_q     <= wdata[CTX_TSAV_BIT];
        soft_q      <= wdata[CTX_SSAV_BIT];
      end
    end else if (lcl_we) begin
      soft_q  <= wdata[0];
      timer_q <= wdata[1];
    end
  end

  always_comb begin
    ctx_word_o = '0;
    ctx_word_o[CTX_LVL_LSB +: LVL_W]   = ctx_q.level;
    ctx_word_o[CTX_NONE_BIT]           = ctx_q.none;
    ctx_word_o[CTX_LINE_LSB +: LINE_W] = ctx_q.line;
    ctx_word_o[CTX_TSAV_BIT]           = ctx_q.t_sav;
    ctx_word_o[CTX_SSAV_BIT]           = ctx_q.s_sav;
  end

  assign level_o    = ctx_q.level;
  assign soft_en_o  = soft_q;
  assign timer_en_o = timer_q;

  p_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && win_any) |=> (!ctx_word_o[CTX_NONE_BIT] &&
      ctx_word_o[CTX_LINE_LSB +: LINE_W] == LINE_W'($past(win_idx))));
  p_update_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !win_any) |=> (level_o == '0 && ctx_word_o[CTX_NONE_BIT]));
  p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && !upd && wdata[CTX_PARK_BIT]) |=> (!soft_en_o && !timer_en_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; #(
  parameter int                NUM_LINES = 64,
  parameter logic [PRIO_W-1:0] PRIO_MASK = '1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wen,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_req,
  output logic                 soft_irq_en,
  output logic                 timer_irq_en
);
  // NUM_LINES: multiple of 16, at most 256
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int FLD       = 16;
  localparam int PER_WORD  = DATA_W / (4 * PRIO_W) * 2;
  localparam int BIT_WORDS = NUM_LINES / FLD;
  localparam int PRI_WORDS = NUM_LINES / PER_WORD;

  logic [NUM_LINES-1:0]        ena_q, frc_q, pend, elig;
  logic [NUM_LINES*PRIO_W-1:0] pri_q;
  logic                        sel_any;
  logic [IDX_W-1:0]            sel_idx;
  logic [PRIO_W-1:0]           sel_pri;
  logic [LVL_W-1:0]            level;
  logic [DATA_W-1:0]           ctx_word, nxt_word;
  logic                        ctx_we, lcl_we, upd;

  assign ctx_we = reg_wen && reg_addr == CTX_ADDR;
  assign lcl_we = reg_wen && reg_addr == LCL_ADDR;
  assign upd    = reg_wen && reg_addr == NXT_ADDR && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      frc_q <= '0;
      pri_q <= '0;
    end else if (reg_wen) begin
      for (int w = 0; w < BIT_WORDS; w++) begin
        if (reg_addr == ADDR_W'(ENA_BASE + w)) ena_q[w*FLD +: FLD] <= reg_wdata[FLD-1:0];
        if (reg_addr == ADDR_W'(FRC_BASE + w)) frc_q[w*FLD +: FLD] <= reg_wdata[FLD-1:0];
      end
      for (int p = 0; p < PRI_WORDS; p++) begin
        if (reg_addr == ADDR_W'(PRI_BASE + p)) begin
          for (int k = 0; k < PER_WORD; k++) begin
            pri_q[(p*PER_WORD + k)*PRIO_W +: PRIO_W] <= reg_wdata[k*PRIO_W +: PRIO_W] & PRIO_MASK;
          end
        end
      end
    end
  end

  assign pend = irq_in | frc_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
    assign elig[g] = ena_q[g] && pend[g] && ({1'b0, pri_q[g*PRIO_W +: PRIO_W]} >= level);
  end

  pic_select #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_select (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (elig),
    .pri_i  (pri_q),
    .any_o  (sel_any),
    .idx_o  (sel_idx),
    .pri_o  (sel_pri)
  );

  pic_context #(.IDX_W(IDX_W), .PRIO_MASK(PRIO_MASK)) u_context (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_we     (ctx_we),
    .lcl_we     (lcl_we),
    .upd        (upd),
    .wdata      (reg_wdata),
    .win_any    (sel_any),
    .win_idx    (sel_idx),
    .win_pri    (sel_pri),
    .level_o    (level),
    .ctx_word_o (ctx_word),
    .soft_en_o  (soft_irq_en),
    .timer_en_o (timer_irq_en)
  );

  always_comb begin
    nxt_word = '0;
    nxt_word[DATA_W-1] = !sel_any;
    nxt_word[2 +: LINE_W] = LINE_W'(sel_idx);
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < BIT_WORDS; w++) begin
      if (reg_addr == ADDR_W'(ENA_BASE + w)) reg_rdata = DATA_W'(ena_q[w*FLD +: FLD]);
      if (reg_addr == ADDR_W'(PND_BASE + w)) reg_rdata = DATA_W'(pend[w*FLD +: FLD]);
      if (reg_addr == ADDR_W'(FRC_BASE + w)) reg_rdata = DATA_W'(frc_q[w*FLD +: FLD]);
    end
    for (int p = 0; p < PRI_WORDS; p++) begin
      if (reg_addr == ADDR_W'(PRI_BASE + p))
        reg_rdata = DATA_W'(pri_q[p*PER_WORD*PRIO_W +: PER_WORD*PRIO_W]);
    end
    if (reg_addr == NXT_ADDR) reg_rdata = nxt_word;
    if (reg_addr == CTX_ADDR) reg_rdata = ctx_word;
    if (reg_addr == LCL_ADDR) reg_rdata = DATA_W'({timer_irq_en, soft_irq_en});
  end

  assign irq_req = sel_any;

  p_req_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, sel_pri} >= level));
  p_force_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == FRC_BASE && reg_wdata[FLD-1:0] == '0) |=> (frc_q[FLD-1:0] == '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  import pic_pkg::*;
  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_req, soft_irq_en, timer_irq_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  // behavioural model state
  bit m_ena[NL];
  bit m_frc[NL];
  int m_pri[NL];
  int m_lvl;
  bit m_none;
  int m_line;
  bit m_tsav, m_ssav, m_te, m_se;

  prio_irq_ctrl #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .soft_irq_en(soft_irq_en), .timer_irq_en(timer_irq_en));

  always #4 clk = ~clk;

  function automatic bit m_elig(int i);
    return m_ena[i] && (irq_in[i] || m_frc[i]) && (m_pri[i] >= m_lvl);
  endfunction

  function automatic int m_win();
    int best = -1;
    for (int i = 0; i < NL; i++)
      if (m_elig(i) && (best < 0 || m_pri[i] > m_pri[best])) best = i;
    return best;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r = 0;
    int w;
    if (a < 8'h04) begin
      for (int b = 0; b < 16; b++) r[b] = m_ena[a*16 + b];
    end else if (a >= 8'h10 && a < 8'h14) begin
      w = a - 8'h10;
      for (int b = 0; b < 16; b++) r[b] = m_ena[0] ? 1'b0 : 1'b0;
      for (int b = 0; b < 16; b++) r[b] = irq_in[w*16 + b] | m_frc[w*16 + b];
    end else if (a >= 8'h20 && a < 8'h24) begin
      for (int b = 0; b < 16; b++) r[b] = m_frc[(a - 8'h20)*16 + b];
    end else if (a >= 8'h40 && a < 8'h50) begin
      w = a - 8'h40;
      for (int k = 0; k < 4; k++) r[k*4 +: 4] = 4'(m_pri[w*4 + k]);
    end else if (a == 8'h80) begin
      w = m_win();
      if (w < 0) r = 32'h8000_0000;
      else r = 32'(w) << 2;
    end else if (a == 8'h81) begin
      r = (32'(m_lvl) << 16) | (32'(m_none) << 15) | (32'(m_line) << 4)
        | (32'(m_tsav) << 3) | (32'(m_ssav) << 2);
    end else if (a == 8'h82) begin
      r = {30'b0, m_te, m_se};
    end
    return r;
  endfunction

  task automatic m_write(logic [7:0] a, logic [31:0] d);
    int w;
    if (a < 8'h04) begin
      for (int b = 0; b < 16; b++) m_ena[a*16 + b] = d[b];
    end else if (a >= 8'h20 && a < 8'h24) begin
      for (int b = 0; b < 16; b++) m_frc[(a - 8'h20)*16 + b] = d[b];
    end else if (a >= 8'h40 && a < 8'h50) begin
      for (int k = 0; k < 4; k++) m_pri[(a - 8'h40)*4 + k] = int'(d[k*4 +: 4]);
    end else if (a == 8'h80 && d[0]) begin
      w = m_win();
      if (w < 0) begin m_lvl = 0; m_none = 1; m_line = 0; end
      else begin m_lvl = m_pri[w] + 1; m_none = 0; m_line = w; end
    end else if (a == 8'h81) begin
      m_lvl = int'(d[20:16]); m_none = d[15]; m_line = int'(d[12:4]);
      if (d[1]) begin
        m_tsav = m_te; m_ssav = m_se; m_te = 0; m_se = 0;
      end else begin
        m_tsav = d[3]; m_ssav = d[2]; m_te = d[3]; m_se = d[2];
      end
    end else if (a == 8'h82) begin
      m_se = d[0]; m_te = d[1];
    end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk);
    #1;
    reg_wen = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(string req, logic [7:0] a);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(req, reg_rdata, m_read(a));
  endtask

  task automatic rd_exp(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(req, reg_rdata, exp);
    chk({req, " model"}, m_read(a), exp);
  endtask

  task automatic set_lines(logic [NL-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic enable(int n, bit v);
    logic [31:0] d = 0;
    m_ena[n] = m_ena[n];
    for (int b = 0; b < 16; b++) d[b] = m_ena[(n & ~15) + b];
    d[n & 15] = v;
    wr(8'(ENA_BASE + (n >> 4)), d);
  endtask

  task automatic set_pri(int n, int p);
    logic [31:0] d = 0;
    for (int k = 0; k < 4; k++) d[k*4 +: 4] = 4'(m_pri[(n & ~3) + k]);
    d[(n % 4)*4 +: 4] = 4'(p);
    wr(8'(PRI_BASE + (n >> 2)), d);
  endtask

  // per-clock comparison of the pins against the model (R2, R10)
  always @(negedge clk) begin
    if (live) begin
      #1;
      chk("R2 irq_req", {31'b0, irq_req}, {31'b0, m_win() >= 0});
      chk("R10 enables", {30'b0, timer_irq_en, soft_irq_en}, {30'b0, m_te, m_se});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_ena[i] = 0; m_frc[i] = 0; m_pri[i] = 0; end
    m_lvl = 0; m_none = 1; m_line = 0;
    m_tsav = 0; m_ssav = 0; m_te = 0; m_se = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd_exp("R1 ctx", CTX_ADDR, 32'h0000_8000);
    rd_exp("R1 next", NXT_ADDR, 32'h8000_0000);
    rd_exp("R1 prio", PRI_BASE, 32'h0);
    chk("R1 irq_req", {31'b0, irq_req}, 32'h0);
    live = 1;

    // R3, R4: layout; line 5 priority 3
    enable(5, 1);
    set_pri(5, 3);
    rd_exp("R4 prio word", 8'h41, 32'h0000_0030);
    rd_exp("R5 none yet", NXT_ADDR, 32'h8000_0000);
    set_lines(64'h20);
    rd_exp("R3 pending", PND_BASE, 32'h0000_0020);
    rd_exp("R5 line5", NXT_ADDR, 32'h0000_0014);
    wr(PND_BASE, 32'hFFFF);
    rd_exp("R3 pending ro", PND_BASE, 32'h0000_0020);

    // R5: tie goes to lower number, then higher priority wins
    enable(40, 1);
    set_pri(40, 3);
    set_lines(64'h0000_0100_0000_0020);
    rd_exp("R5 tie", NXT_ADDR, 32'h0000_0014);
    set_pri(40, 7);
    rd_exp("R4 prio40", 8'h4A, 32'h0000_0007);
    rd_exp("R5 higher", NXT_ADDR, 32'h0000_00A0);

    // R2: disabled line is not eligible
    enable(40, 0);
    rd_exp("R2 disabled", NXT_ADDR, 32'h0000_0014);
    enable(40, 1);

    // R11: force line 63 with priority 9, then clear
    enable(63, 1);
    set_pri(63, 9);
    wr(8'h23, 32'h8000);
    rd_exp("R11 forced", NXT_ADDR, 32'h0000_00FC);
    rd_exp("R3 force word", 8'h23, 32'h0000_8000);
    wr(8'h23, 32'h0);
    rd_exp("R11 cleared", NXT_ADDR, 32'h0000_00A0);

    // R6: update latches line 40 priority 7 -> level 8
    wr(NXT_ADDR, 32'h1);
    rd_exp("R6 ctx", CTX_ADDR, 32'h0008_0280);
    rd_exp("R2 below level", NXT_ADDR, 32'h8000_0000);
    chk("R2 no req", {31'b0, irq_req}, 32'h0);

    // R6: write without bit 0 changes nothing
    wr(NXT_ADDR, 32'h0);
    rd_exp("R6 no update", CTX_ADDR, 32'h0008_0280);

    // R7: late arrival at priority 12
    enable(10, 1);
    set_pri(10, 12);
    set_lines(64'h0000_0100_0000_0420);
    rd_exp("R7 late", NXT_ADDR, 32'h0000_0028);
    wr(NXT_ADDR, 32'h1);
    rd_exp("R7 latched", CTX_ADDR, 32'h000D_00A0);

    // R6: priority 15 gives level 16, nothing preempts it
    enable(20, 1);
    enable(21, 1);
    set_pri(20, 15);
    set_pri(21, 15);
    set_lines(64'h0000_0100_0030_0420);
    rd_exp("R5 p15 tie", NXT_ADDR, 32'h0000_0050);
    wr(NXT_ADDR, 32'h1);
    rd_exp("R6 level16", CTX_ADDR, 32'h0010_0140);
    rd_exp("R6 no preempt", NXT_ADDR, 32'h8000_0000);

    // R10, R9: park and restore local enables
    wr(LCL_ADDR, 32'h3);
    rd_exp("R10 lcl", LCL_ADDR, 32'h3);
    wr(CTX_ADDR, 32'h0000_8002);
    rd_exp("R9 parked", CTX_ADDR, 32'h0000_800C);
    rd_exp("R9 cleared", LCL_ADDR, 32'h0);
    rd("R2 ctx restored", NXT_ADDR);
    wr(CTX_ADDR, 32'h0008_028C);
    rd_exp("R8 ctx reload", CTX_ADDR, 32'h0008_028C);
    rd_exp("R9 restored", LCL_ADDR, 32'h3);
    rd_exp("R8 level8 next", NXT_ADDR, 32'h0000_0050);

    // R6: update with no eligible line
    set_lines('0);
    wr(NXT_ADDR, 32'h1);
    rd_exp("R6 none", CTX_ADDR, 32'h0000_800C);

    repeat (4) @(negedge clk);
    live = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule